// File: doc/BRIEF.md
# Prioritized Interrupt State Vector Register

This block sits between a serial data-link engine and a CPU. The link engine raises single-cycle event pulses, one for each interrupt source. The block holds each source as a sticky pending flag. It reduces the pending set to one 4-bit code that names the most urgent source. The code is presented shifted left by two, so a read of the 8-bit vector register yields a multiple of four. Software can add that value directly to the base of a jump table.

Most sources are acknowledged by reading the vector register itself. The three data-related sources work differently. Two are receive-side: a received in-frame-response byte and a full receive data register. One is transmit-side: an empty transmit data register. Each of these needs a two-access sequence. First, a vector read must report that exact source, which arms it. Then the next access to the data register clears it: a read for the receive sources, a write for the transmit source. The transmit source can also be dropped at once through a transmit-end-of-data control input. An interrupt request output is high whenever any source is pending.

Top module: `irqvec_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the vector reads 0x00 and the interrupt request is low; reset discards all pending sources.
- R2: Event input bit k marks source code k+1 as pending. The vector register shows the code in bits 5:2, with bits 7, 6, 1 and 0 at zero. The codes are: 1 end-of-frame, 2 response byte received, 3 receive data full, 4 transmit data empty, 5 arbitration lost, 6 CRC error, 7 invalid symbol, 8 wakeup.
- R3: When several sources are pending, the vector shows the highest code among them.
- R4: The interrupt request output is high exactly when the vector is non-zero.
- R5: A vector read clears the source it reports when that code is 1, 5, 6, 7 or 8. On the next clock the vector shows the next-highest pending source.
- R6: A vector read alone never clears code 2, 3 or 4.
- R7: Codes 2 and 3 clear on a data-register read that follows a vector read reporting that code. A data-register write does not clear them.
- R8: Code 4 clears on a data-register write that follows a vector read reporting code 4. A data-register read does not clear it.
- R9: While the transmit-end-of-data input is high, code 4 is cleared, with no vector read needed.
- R10: A data-register access clears nothing unless the vector read before it reported that same source. Any data-register access disarms the sequence, so a second access clears nothing.
- R11: An event that arrives in the same cycle as a clear condition for its source wins, and the source stays pending.
- R12: A pending source stays pending until one of its own clear conditions occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcEvent | input | 8 | Event pulses; bit k sets source code k+1 |
| vecRd | input | 1 | CPU read strobe of the vector register |
| dataRd | input | 1 | CPU read strobe of the data register |
| dataWr | input | 1 | CPU write strobe of the data register |
| txEndData | input | 1 | Transmit-end-of-data control bit |
| vecOut | output | 8 | Vector register value (code in bits 5:2) |
| irqOut | output | 1 | Interrupt request |

## Verification
The bench targets the arming rule in several ways. It sends a data read with no prior vector read. It sends a data write after a receive source was armed. It repeats a data read after the arm has already been used. A design that cleared on any data access, or that failed to disarm, would drop code 2 or 3 too early. It also raises an event in the same cycle as the read or control bit that would clear it; a design where the clear wins would lose that event. Finally, it reads the vector repeatedly down a stack of four pending sources. This catches a wrong priority order, or a vector that does not step to the next source after a clear.

// File: rtl/irqvec_pkg.sv
package irqvec_pkg;
  localparam int NUM_SRC    = 8;
  localparam int SRC_CODE_W = $clog2(NUM_SRC + 1);

  // source classes, bit k = code k+1
  localparam logic [NUM_SRC-1:0] RX_MASK   = NUM_SRC'(8'b0000_0110);
  localparam logic [NUM_SRC-1:0] TX_MASK   = NUM_SRC'(8'b0000_1000);
  localparam logic [NUM_SRC-1:0] DATA_MASK = RX_MASK | TX_MASK;

  typedef struct packed {
    logic [NUM_SRC-1:0] readClr;   // clear by vector read
    logic [NUM_SRC-1:0] dataClr;   // clear by armed data access
    logic [NUM_SRC-1:0] txEndClr;  // clear by end-of-data bit
  } irqStrobes_t;
endpackage

// File: rtl/irqvec_ctrl.sv
module irqvec_ctrl
  import irqvec_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  vecRd,
  input  logic                  dataRd,
  input  logic                  dataWr,
  input  logic                  txEndData,
  input  logic [SRC_CODE_W-1:0] curCode,
  output irqStrobes_t           strobes
);
  logic [SRC_CODE_W-1:0] armCode;
  logic [SRC_CODE_W-1:0] armNext;
  logic                  curIsData;

  always_comb begin
    strobes   = '0;
    curIsData = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (curCode == SRC_CODE_W'(i + 1)) begin
        strobes.readClr[i] = vecRd & ~DATA_MASK[i];
        curIsData          = DATA_MASK[i];
      end
      if (armCode == SRC_CODE_W'(i + 1)) begin
        strobes.dataClr[i] = (dataRd & RX_MASK[i]) | (dataWr & TX_MASK[i]);
      end
    end
    strobes.txEndClr = txEndData ? TX_MASK : '0;
  end

  always_comb begin
    armNext = armCode;
    if (vecRd)                 armNext = curIsData ? curCode : '0;
    else if (dataRd || dataWr) armNext = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) armCode <= '0;
    else       armCode <= armNext;
  end

  // R10: a data access without a same-cycle vector read leaves nothing armed
  p_disarm_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((dataRd || dataWr) && !vecRd) |=> (armCode == '0));
endmodule

// File: rtl/irqvec_dpath.sv
module irqvec_dpath
  import irqvec_pkg::*;
#(
  parameter int REG_W     = 8,
  parameter int VEC_SHIFT = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_SRC-1:0]    srcEvent,
  input  irqStrobes_t           strobes,
  output logic [NUM_SRC-1:0]    pendFlags,
  output logic [SRC_CODE_W-1:0] curCode,
  output logic [REG_W-1:0]      vecOut,
  output logic                  irqOut
);
  logic [NUM_SRC-1:0] clrMask;

  assign clrMask = strobes.readClr | strobes.dataClr | strobes.txEndClr;

  always_ff @(posedge clk) begin
    if (!rstN) pendFlags <= '0;
    else       pendFlags <= (pendFlags & ~clrMask) | srcEvent;
  end

  always_comb begin
    curCode = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pendFlags[i]) curCode = SRC_CODE_W'(i + 1);
    end
  end

  assign vecOut = REG_W'(curCode) << VEC_SHIFT;
  assign irqOut = |curCode;

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_flagChk
    // R11: an event always leaves its flag set
    p_event_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
      srcEvent[gi] |=> pendFlags[gi]);
    // R12: without a clear the flag holds
    p_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
      (pendFlags[gi] && !clrMask[gi]) |=> pendFlags[gi]);
  end

  // R4: request can only rise after an event
  p_irq_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(|srcEvent));
endmodule

// File: rtl/irqvec_top.sv
module irqvec_top
  import irqvec_pkg::*;
#(
  parameter int REG_W     = 8,
  parameter int VEC_SHIFT = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcEvent,
  input  logic               vecRd,
  input  logic               dataRd,
  input  logic               dataWr,
  input  logic               txEndData,
  output logic [REG_W-1:0]   vecOut,
  output logic               irqOut
);
  irqStrobes_t           strobes;
  logic [NUM_SRC-1:0]    pendFlags;
  logic [SRC_CODE_W-1:0] curCode;

  irqvec_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .vecRd(vecRd), .dataRd(dataRd), .dataWr(dataWr),
    .txEndData(txEndData), .curCode(curCode), .strobes(strobes)
  );

  irqvec_dpath #(.REG_W(REG_W), .VEC_SHIFT(VEC_SHIFT)) u_dpath (
    .clk(clk), .rstN(rstN), .srcEvent(srcEvent), .strobes(strobes),
    .pendFlags(pendFlags), .curCode(curCode), .vecOut(vecOut), .irqOut(irqOut)
  );

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_clrChk
    if (!DATA_MASK[gi]) begin : g_nonData
      // R5: reading a reported non-data source clears it
      p_read_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
        (vecRd && curCode == SRC_CODE_W'(gi + 1) && !srcEvent[gi]) |=> !pendFlags[gi]);
    end else if (RX_MASK[gi]) begin : g_rx
      // R6: receive sources survive any cycle with no data read
      p_rx_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
        (pendFlags[gi] && !dataRd) |=> pendFlags[gi]);
    end else begin : g_tx
      // R6: transmit source survives without a data write or end-of-data
      p_tx_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
        (pendFlags[gi] && !dataWr && !txEndData) |=> pendFlags[gi]);
    end
  end
endmodule

// File: tb/irqvec_top_tb.sv
module irqvec_top_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] srcEvent = '0;
  logic       vecRd = 1'b0, dataRd = 1'b0, dataWr = 1'b0, txEndData = 1'b0;
  logic [7:0] vecOut;
  logic       irqOut;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irqvec_top u_dut (
    .clk(clk), .rstN(rstN), .srcEvent(srcEvent), .vecRd(vecRd), .dataRd(dataRd),
    .dataWr(dataWr), .txEndData(txEndData), .vecOut(vecOut), .irqOut(irqOut)
  );

  // entry: {req[3:0], event[7:0], vecRd, dataRd, dataWr, txEnd, expVec[7:0]}
  localparam int NSTEP = 34;
  localparam logic [23:0] STEPS [NSTEP] = '{
    {4'd2,  8'h01, 4'b0000, 8'h04},  // R2 end-of-frame
    {4'd12, 8'h00, 4'b0000, 8'h04},  // R12 sticky
    {4'd5,  8'h00, 4'b1000, 8'h00},  // R5 read clears
    {4'd3,  8'h06, 4'b0000, 8'h0C},  // R3 codes 2 and 3
    {4'd6,  8'h00, 4'b1000, 8'h0C},  // R6 read alone, arms 3
    {4'd7,  8'h00, 4'b0100, 8'h08},  // R7 data read clears 3
    {4'd6,  8'h00, 4'b1000, 8'h08},  // R6 arms 2
    {4'd7,  8'h00, 4'b0010, 8'h08},  // R7 write does not clear rx
    {4'd10, 8'h00, 4'b0100, 8'h08},  // R10 disarmed by write
    {4'd6,  8'h00, 4'b1000, 8'h08},  // R6 arms 2 again
    {4'd7,  8'h00, 4'b0100, 8'h00},  // R7 clears 2
    {4'd2,  8'h08, 4'b0000, 8'h10},  // R2 tx empty
    {4'd6,  8'h00, 4'b1000, 8'h10},  // R6 arms 4
    {4'd8,  8'h00, 4'b0100, 8'h10},  // R8 read does not clear tx
    {4'd6,  8'h00, 4'b1000, 8'h10},  // R6 arms 4
    {4'd8,  8'h00, 4'b0010, 8'h00},  // R8 write clears
    {4'd2,  8'h08, 4'b0000, 8'h10},
    {4'd9,  8'h00, 4'b0001, 8'h00},  // R9 end-of-data clears
    {4'd3,  8'hF0, 4'b0000, 8'h20},  // R3 wakeup on top
    {4'd5,  8'h00, 4'b1000, 8'h1C},  // R5 next highest
    {4'd5,  8'h00, 4'b1000, 8'h18},
    {4'd5,  8'h00, 4'b1000, 8'h14},
    {4'd5,  8'h00, 4'b1000, 8'h00},
    {4'd2,  8'h01, 4'b1000, 8'h04},  // read of empty vector, then event
    {4'd11, 8'h01, 4'b1000, 8'h04},  // R11 event beats read clear
    {4'd5,  8'h00, 4'b1000, 8'h00},
    {4'd2,  8'h08, 4'b0000, 8'h10},
    {4'd11, 8'h08, 4'b0001, 8'h10},  // R11 event beats end-of-data
    {4'd9,  8'h00, 4'b0001, 8'h00},
    {4'd2,  8'h04, 4'b0000, 8'h0C},
    {4'd10, 8'h00, 4'b0100, 8'h0C},  // R10 data read with no prior vector read
    {4'd6,  8'h00, 4'b1000, 8'h0C},
    {4'd7,  8'h00, 4'b0100, 8'h00},
    {4'd1,  8'h00, 4'b0000, 8'h00}
  };

  task automatic check(input int req, input logic [7:0] expVec);
    logic expIrq;
    expIrq = (expVec != 8'h00);
    checks++;
    if (vecOut !== expVec) begin
      errors++;
      $display("FAIL R%0d vecOut actual %h expected %h", req, vecOut, expVec);
    end
    checks++;  // R4 request follows vector
    if (irqOut !== expIrq) begin
      errors++;
      $display("FAIL R4 irqOut actual %b expected %b (step R%0d)", irqOut, expIrq, req);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    check(1, 8'h00);  // R1 during reset
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(1, 8'h00);  // R1 after release

    for (int s = 0; s < NSTEP; s++) begin
      srcEvent  = STEPS[s][19:12];
      vecRd     = STEPS[s][11];
      dataRd    = STEPS[s][10];
      dataWr    = STEPS[s][9];
      txEndData = STEPS[s][8];
      @(negedge clk);
      check(int'(STEPS[s][23:20]), STEPS[s][7:0]);
    end
    srcEvent = '0; vecRd = 0; dataRd = 0; dataWr = 0; txEndData = 0;

    // R2 each source alone, R1 reset discards it
    for (int k = 0; k < 8; k++) begin
      srcEvent = 8'(1 << k);
      @(negedge clk);
      srcEvent = '0;
      check(2, 8'((k + 1) << 2));
      rstN = 1'b0;
      @(negedge clk);
      rstN = 1'b1;
      check(1, 8'h00);
      @(negedge clk);
    end

    // R10: arm used once, re-raised flag not cleared by a second read
    srcEvent = 8'h04;
    @(negedge clk);
    srcEvent = '0; vecRd = 1;
    @(negedge clk);
    vecRd = 0; dataRd = 1;
    @(negedge clk);
    dataRd = 0; srcEvent = 8'h04;
    @(negedge clk);
    srcEvent = '0; dataRd = 1;
    @(negedge clk);
    dataRd = 0;
    check(10, 8'h0C);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule